// File: doc/BRIEF.md
# USB Host Transaction Gate with Babble Detection

This block sits between the frame scheduler of a USB host controller and the packet engine. It decides the bit time at which a queued bus transaction may be launched, and it watches the bus for a device that is still talking when the frame ends. A transaction goes out only after two things are true. The bus must have stayed quiet for a programmable number of bit times. The transaction's estimated length must also fit into what is left of the current frame. A request that does not fit is held and tried again in the next frame.

The block derives a bit-time tick from the system clock with a clock divider, and it counts frame position in those ticks. If the bus is still active on the last tick of a frame, the block treats the attached device as faulty. It raises a babble interrupt and enters a halted state in which no transaction is launched until software clears it. While a launched transaction is still inside its estimated duration, a busy flag is high. Software must wait for that flag to drop before it moves endpoints to another device.

The controller has five states. GS_IDLE waits for a request. GS_ARMED holds a request until it can be launched. GS_DEFER holds a refused request until the frame boundary. GS_XFER covers a transaction in flight. GS_HALT is the state after babble. The transitions are:
- accept: GS_IDLE to GS_ARMED on a request.
- launch: GS_ARMED to GS_XFER on a tick with enough idle time and enough room in the frame.
- refuse: GS_ARMED to GS_DEFER on such a tick when the request does not fit, unless that tick ends the frame.
- retry: GS_DEFER to GS_ARMED on the end-of-frame tick.
- finish: GS_XFER to GS_IDLE on the tick where the duration runs out.
- babble: any state other than GS_HALT to GS_HALT.
- clear: GS_HALT to GS_IDLE on the clear pulse.

Top module: `usb_txn_gate`

## Requirements
- R1: A start is issued only on a bit tick at which at least IPD_BITS whole bit ticks have passed with bus_active low. Any clock cycle with bus_active high sets that idle count back to zero.
- R2: A start is issued only when the requested duration in bit ticks is no more than FRAME_BITS-1 minus the current frame position. A requested duration of zero is treated as one.
- R3: If bus_active is high during the end-of-frame tick, babble_irq goes high on the next clock cycle. It stays high until it is cleared.
- R4: After babble, halted_o is high. No start is issued and req_valid is ignored. A halt_clr pulse while halted returns the block to GS_IDLE and drops babble_irq and halted_o on the next cycle. A halt_clr pulse while not halted has no effect.
- R5: busy_o rises together with start_o and stays high for exactly the requested number of bit ticks. It falls on the cycle after the last of those ticks.
- R6: A request that is refused for lack of room stays pending, with no resend, and is evaluated again from the first tick of the next frame.
- R7: While sched_en is low, no start is issued and the pending request is kept.
- R8: Timing: a bit tick occurs on clock cycles where the number of clock edges since reset, taken modulo CLK_PER_BIT, equals CLK_PER_BIT-1. Frame position counts ticks modulo FRAME_BITS starting from 0, and the end-of-frame tick is the tick at position FRAME_BITS-1. start_o is a one-cycle pulse on the cycle after the deciding tick.
- R9: During and just after reset, start_o, busy_o, babble_irq and halted_o are low.
- R10: req_valid is captured only in GS_IDLE. A request that arrives while another is pending or in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_active | input | 1 | High while the line shows any non-idle signalling |
| sched_en | input | 1 | Scheduler permission to launch transactions |
| req_valid | input | 1 | One-cycle pulse offering a transaction |
| req_bits | input | DUR_W | Estimated transaction length in bit ticks |
| halt_clr | input | 1 | Software pulse that leaves the halted state |
| start_o | output | 1 | One-cycle launch strobe |
| busy_o | output | 1 | A launched transaction is within its duration |
| babble_irq | output | 1 | Latched babble interrupt |
| halted_o | output | 1 | Traffic blocked after babble |

## Verification
Every output of this block is registered. start_o, busy_o, halted_o and babble_irq all change on the clock edge that closes the deciding cycle, so each of them is due exactly one edge after the tick or input pulse that causes it. The bench drives inputs on falling edges. On each rising edge, a spec-level predictor turns the sampled inputs into the expected four outputs and pushes them into a queue. On the next falling edge, the monitor pops that entry and compares it with the ports, so a change that is one cycle late or early shows as a mismatch. Directed checks then confirm the babble and clear cases one cycle after the edge that causes them.

// File: rtl/usb_gate_pkg.sv
package usb_gate_pkg;

    typedef enum logic [2:0] {
        GS_IDLE  = 3'd0,
        GS_ARMED = 3'd1,
        GS_DEFER = 3'd2,
        GS_XFER  = 3'd3,
        GS_HALT  = 3'd4
    } gate_state_e;

endpackage

// File: rtl/gate_bit_tick.sv
module gate_bit_tick #(
    parameter int CLK_PER_BIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_BIT - 1);

    logic [CW-1:0] div_q;

    assign tick_o = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (tick_o) div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/gate_frame_timer.sv
module gate_frame_timer #(
    parameter int FRAME_BITS = 12000,
    localparam int PW = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    output logic [PW-1:0] left_o,
    output logic          eof_o
);
    localparam logic [PW-1:0] LAST = PW'(FRAME_BITS - 1);

    logic [PW-1:0] pos_q;

    assign left_o = LAST - pos_q;
    assign eof_o  = tick_i && (pos_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n)      pos_q <= '0;
        else if (eof_o)  pos_q <= '0;
        else if (tick_i) pos_q <= pos_q + 1'b1;
    end

    // R8
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> (left_o == LAST));

endmodule

// File: rtl/gate_idle_timer.sv
module gate_idle_timer #(
    parameter int IPD_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic bus_active_i,
    output logic idle_ok_o
);
    localparam int CW = $clog2(IPD_BITS + 1);
    localparam logic [CW-1:0] NEED = CW'(IPD_BITS);

    logic [CW-1:0] quiet_q;

    assign idle_ok_o = (quiet_q >= NEED);

    always_ff @(posedge clk) begin
        if (!rst_n)                        quiet_q <= '0;
        else if (bus_active_i)             quiet_q <= '0;
        else if (tick_i && !idle_ok_o)     quiet_q <= quiet_q + 1'b1;
    end

    // R1
    idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active_i |=> !idle_ok_o);

endmodule

// File: rtl/usb_txn_gate.sv
module usb_txn_gate
    import usb_gate_pkg::*;
#(
    parameter int CLK_PER_BIT = 4,
    parameter int FRAME_BITS  = 12000,
    parameter int IPD_BITS    = 8,
    parameter int DUR_W       = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_active,
    input  logic             sched_en,
    input  logic             req_valid,
    input  logic [DUR_W-1:0] req_bits,
    input  logic             halt_clr,
    output logic             start_o,
    output logic             busy_o,
    output logic             babble_irq,
    output logic             halted_o
);
    localparam int PW   = $clog2(FRAME_BITS);
    localparam int CMPW = ((DUR_W > PW) ? DUR_W : PW) + 1;

    logic          tick_w;
    logic          eof_w;
    logic          idle_ok_w;
    logic [PW-1:0] left_w;

    gate_state_e      state_q, state_d;
    logic [DUR_W-1:0] dur_q, dur_d;
    logic [DUR_W-1:0] run_q, run_d;
    logic             fit_w;
    logic             go_start;
    logic             babble_now;

    gate_bit_tick #(.CLK_PER_BIT(CLK_PER_BIT)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick_w)
    );

    gate_frame_timer #(.FRAME_BITS(FRAME_BITS)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_w),
        .left_o (left_w),
        .eof_o  (eof_w)
    );

    gate_idle_timer #(.IPD_BITS(IPD_BITS)) u_idle (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_w),
        .bus_active_i (bus_active),
        .idle_ok_o    (idle_ok_w)
    );

    assign fit_w      = CMPW'(dur_q) <= CMPW'(left_w);
    assign babble_now = eof_w && bus_active && (state_q != GS_HALT);

    always_comb begin
        state_d  = state_q;
        dur_d    = dur_q;
        run_d    = run_q;
        go_start = 1'b0;
        if (babble_now) begin
            state_d = GS_HALT;
        end else begin
            unique case (state_q)
                GS_IDLE: begin
                    if (req_valid) begin
                        state_d = GS_ARMED;
                        dur_d   = (req_bits == '0) ? DUR_W'(1) : req_bits;
                    end
                end
                GS_ARMED: begin
                    if (tick_w && sched_en && idle_ok_w) begin
                        if (fit_w) begin
                            state_d  = GS_XFER;
                            run_d    = dur_q;
                            go_start = 1'b1;
                        end else if (!eof_w) begin
                            state_d = GS_DEFER;
                        end
                    end
                end
                GS_DEFER: begin
                    if (eof_w) state_d = GS_ARMED;
                end
                GS_XFER: begin
                    if (tick_w) begin
                        if (run_q <= DUR_W'(1)) state_d = GS_IDLE;
                        else                    run_d   = run_q - 1'b1;
                    end
                end
                GS_HALT: begin
                    if (halt_clr) state_d = GS_IDLE;
                end
                default: state_d = GS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
            dur_q   <= '0;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            dur_q   <= dur_d;
            run_q   <= run_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o    <= 1'b0;
            babble_irq <= 1'b0;
        end else begin
            start_o <= go_start;
            if (babble_now)                         babble_irq <= 1'b1;
            else if (state_q == GS_HALT && halt_clr) babble_irq <= 1'b0;
        end
    end

    assign busy_o   = (state_q == GS_XFER);
    assign halted_o = (state_q == GS_HALT);

    // R1
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(idle_ok_w));

    // R2
    start_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(fit_w));

    // R3
    babble_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(babble_irq) |-> $past(eof_w && bus_active));

    // R4
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !start_o);

    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !halted_o) |-> $past(tick_w));

    // R7
    sched_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(sched_en));

    // R4
    state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, halted_o}));

endmodule

// File: tb/usb_txn_gate_tb.sv
module usb_txn_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CPB = 2;
    localparam int FB  = 40;
    localparam int IPD = 3;
    localparam int DW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_active = 1'b0;
    logic          sched_en = 1'b1;
    logic          req_valid = 1'b0;
    logic [DW-1:0] req_bits = '0;
    logic          halt_clr = 1'b0;
    logic          start_o, busy_o, babble_irq, halted_o;

    int checks = 0;
    int errors = 0;

    usb_txn_gate #(.CLK_PER_BIT(CPB), .FRAME_BITS(FB), .IPD_BITS(IPD), .DUR_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .sched_en(sched_en),
        .req_valid(req_valid), .req_bits(req_bits), .halt_clr(halt_clr),
        .start_o(start_o), .busy_o(busy_o), .babble_irq(babble_irq), .halted_o(halted_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int cyc;
        bit st;
        bit irq;
        bit hlt;
        bit bsy;
    } exp_t;
    exp_t q[$];

    // Spec-level predictor: 0 idle, 1 armed, 2 deferred, 3 in flight, 4 halted
    int cyc = 0;
    int ms = 0;
    int mdur = 0;
    int mleft = 0;
    int midle = 0;
    bit mstart = 0;
    bit mirq = 0;

    always @(posedge clk) begin
        bit tk, eofm, ok;
        int pos, room;
        exp_t e;
        if (!rst_n) begin
            cyc = 0; ms = 0; midle = 0; mirq = 0; mstart = 0; mdur = 0; mleft = 0;
        end else begin
            tk   = (cyc % CPB) == CPB - 1;
            pos  = (cyc / CPB) % FB;
            room = FB - 1 - pos;
            eofm = tk && (pos == FB - 1);
            ok   = midle >= IPD;
            mstart = 0;
            if (eofm && bus_active && ms != 4) begin
                ms = 4; mirq = 1;
            end else begin
                case (ms)
                    0: if (req_valid) begin ms = 1; mdur = (req_bits == 0) ? 1 : int'(req_bits); end
                    1: if (tk && sched_en && ok) begin
                           if (mdur <= room) begin ms = 3; mstart = 1; mleft = mdur; end
                           else if (!eofm) ms = 2;
                       end
                    2: if (eofm) ms = 1;
                    3: if (tk) begin if (mleft <= 1) ms = 0; else mleft = mleft - 1; end
                    4: if (halt_clr) begin ms = 0; mirq = 0; end
                    default: ms = 0;
                endcase
            end
            if (bus_active) midle = 0;
            else if (tk && midle < IPD) midle = midle + 1;
            cyc = cyc + 1;
            e.cyc = cyc; e.st = mstart; e.irq = mirq; e.hlt = (ms == 4); e.bsy = (ms == 3);
            q.push_back(e);
        end
    end

    // Monitor: compare one cycle of expected outputs per falling edge
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (start_o !== e.st) begin
                errors++;
                $display("FAIL R1 R2 R6 R7 R8 start_o cyc=%0d act=%0b exp=%0b", e.cyc, start_o, e.st);
            end
            checks++;
            if (babble_irq !== e.irq) begin
                errors++;
                $display("FAIL R3 babble_irq cyc=%0d act=%0b exp=%0b", e.cyc, babble_irq, e.irq);
            end
            checks++;
            if (halted_o !== e.hlt) begin
                errors++;
                $display("FAIL R4 halted_o cyc=%0d act=%0b exp=%0b", e.cyc, halted_o, e.hlt);
            end
            checks++;
            if (busy_o !== e.bsy) begin
                errors++;
                $display("FAIL R5 R10 busy_o cyc=%0d act=%0b exp=%0b", e.cyc, busy_o, e.bsy);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp_v);
        end
    endtask

    task automatic idle_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_req(input int d);
        @(negedge clk);
        req_bits  = DW'(d);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_pos(input int p);
        do @(negedge clk); while (((cyc / CPB) % FB) != p || (cyc % CPB) != 0);
    endtask

    task automatic recover();
        if (halted_o) begin
            @(negedge clk); halt_clr = 1'b1;
            @(negedge clk); halt_clr = 1'b0;
        end
        while (busy_o) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                // R9: reset state
                repeat (3) @(negedge clk);
                chk(start_o == 0 && busy_o == 0, "R9 reset start/busy", {start_o, busy_o}, 0);
                chk(babble_irq == 0 && halted_o == 0, "R9 reset irq/halt", {babble_irq, halted_o}, 0);
                rst_n = 1'b1;
                @(negedge clk);
                chk(start_o == 0 && halted_o == 0, "R9 after release", {start_o, halted_o}, 0);

                // plain launch on an idle bus
                idle_n(10); send_req(5); idle_n(30);

                // R1: activity restarts the idle count
                recover(); send_req(4);
                bus_active = 1; idle_n(3); bus_active = 0; idle_n(3);
                bus_active = 1; idle_n(1); bus_active = 0; idle_n(40);

                // R7: scheduler permission
                recover(); sched_en = 0; send_req(3); idle_n(30); sched_en = 1; idle_n(30);

                // R6: refused near frame end, retried next frame
                recover(); wait_pos(33); send_req(10); idle_n(100);

                // R2: full-frame length and zero length
                recover(); wait_pos(10); send_req(39); idle_n(120);
                recover(); send_req(0); idle_n(20);

                // R10: request during flight is dropped
                recover(); send_req(20); idle_n(6); send_req(2); idle_n(60);

                // R3 R4: babble across the frame boundary
                recover(); wait_pos(37); bus_active = 1; idle_n(8); bus_active = 0;
                @(negedge clk);
                chk(babble_irq == 1, "R3 babble raised", babble_irq, 1);
                chk(halted_o == 1, "R4 halted after babble", halted_o, 1);
                send_req(2); idle_n(30);
                chk(start_o == 0 && busy_o == 0, "R4 request ignored while halted", {start_o, busy_o}, 0);
                halt_clr = 1; @(negedge clk); halt_clr = 0;
                chk(babble_irq == 0 && halted_o == 0, "R4 cleared", {babble_irq, halted_o}, 0);
                send_req(3); idle_n(30);

                // R4: clear outside halt has no effect
                halt_clr = 1; @(negedge clk); halt_clr = 0;
                chk(halted_o == 0 && babble_irq == 0, "R4 stray clear", {halted_o, babble_irq}, 0);
                send_req(2); idle_n(30);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired act=1 exp=0");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule